// File: doc/BRIEF.md
# Dual-Channel Reload Down-Counter Timer

This block holds two independent down-counting timer channels behind a single-cycle register bus. A shared global control word gates both channels. Each channel has its own control word and its own count word. The control word selects a tick source, a power-of-two prescale, reload, update and interrupt-enable behaviour, and holds a sticky pending flag. The count word shows the live count in its upper half and the programmed reload value in its lower half. Software that wants a rising time base inverts the upper half.

Control words can be written in three ways: a full replace, a set alias that ORs in the written ones, and a clear alias that removes them. Each channel raises its own interrupt line while its pending flag and its enable bit are both set.

Each channel is run by a three-state machine. CH_OFF is entered whenever the global gate or soft reset is active. CH_RUN means counting is allowed. CH_HELD means the count is parked at zero with reload clear. The transitions are:
- OFF→RUN and OFF→HELD when the block becomes enabled, chosen by whether the count is parked.
- RUN→HELD when zero is reached with reload clear.
- HELD→RUN when a nonzero count is loaded or reload is set.
- RUN→OFF and HELD→OFF when the block is disabled.

Each transition takes effect one clock after its cause.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, the global word reads 0xC000_0000 (bit 31 soft reset, bit 30 clock gate). All channel words read zero and both interrupt lines are low.
- R2: Word address = block*8 + slot. Block 0 is global, and block n+1 is channel n. Slot 0 replaces the word, slot 1 ORs in the written ones, slot 2 clears the written ones, and slot 3 is a channel's count word. In the channel control word, bits 3:0 are select, 5:4 prescale, 6 reload, 7 update, 14 interrupt enable and 15 pending flag. The other bits read zero.
- R3: The count word reads {live count, reload value} in bits 31:16 and 15:0. A count-word write stores bits 15:0 as the reload value. When update is set, the same write also loads the live count.
- R4: When update is clear, a count-word write changes only the reload value and leaves the live count as it was.
- R5: With select 8, each slow_tick pulse is a source tick. With select 0xF, every clock is a source tick. Any other select value produces no tick, so the count does not change.
- R6: With prescale p, the count steps once every 2^p source ticks. The prescale phase restarts on a count-word write and whenever the channel is not running.
- R7: A prescaled tick at a nonzero count decrements it. At zero, it reloads the reload value if reload is set; otherwise the count stays at zero.
- R8: The pending flag is set on the step from 1 to 0 and stays set until software clears it. The interrupt line equals the flag AND the enable bit.
- R9: When the hardware sets the flag in the same cycle that software clears it, the flag ends up set.
- R10: The count does not change while soft reset or clock gate is set, except through count-word writes.
- R11: Setting soft reset zeroes every channel word and forces the clock-gate bit to 1. Clearing only soft reset afterwards leaves the gate set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (5) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| slow_tick | input | 1 | Low-rate tick enable, one clock wide |
| irq | output | NUM_CH (2) | Per-channel interrupt lines |

## Verification
A channel can finish its count by stepping from 1 to 0 in the same cycle that software writes the clear alias for its pending flag. The bench provokes this with a channel that ticks on every clock. It loads a count of 1, spends one cycle on an ordinary flag clear, and then lands a second flag clear exactly on the edge where the count reaches zero. The flag and the interrupt line are judged afterwards: they must be set, because the hardware set has priority. A separate plain clear, with no collision, must drop both.

// File: rtl/dual_tmr_pkg.sv
package dual_tmr_pkg;

    localparam int BUS_W      = 32;
    localparam int CTRL_W     = 16;
    localparam int SEL_LSB    = 0;
    localparam int SEL_W      = 4;
    localparam int PRE_LSB    = 4;
    localparam int PRE_W      = 2;
    localparam int RELOAD_BIT = 6;
    localparam int UPDATE_BIT = 7;
    localparam int IEN_BIT    = 14;
    localparam int FLAG_BIT   = 15;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hC0FF;

    localparam logic [SEL_W-1:0] SEL_SLOW   = 4'h8;
    localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'hF;

    localparam int SFTRST_BIT = 31;
    localparam int GATE_BIT   = 30;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_COUNT = 2'd3
    } reg_op_e;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HELD = 2'd2
    } ch_state_e;

    function automatic logic [BUS_W-1:0] alias_merge(
        input reg_op_e          op,
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wd
    );
        logic [BUS_W-1:0] res;
        unique case (op)
            OP_WRITE: res = wd;
            OP_SET:   res = cur | wd;
            OP_CLR:   res = cur & ~wd;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/dual_tmr_global.sv
module dual_tmr_global
    import dual_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_op_e          op,
    input  logic [BUS_W-1:0] wdata,
    output logic             sftrst_q,
    output logic             gate_q,
    output logic             run_en
);

    logic [BUS_W-1:0] cur_word;
    logic [BUS_W-1:0] merged;
    logic             sftrst_d;
    logic             gate_d;

    always_comb begin
        cur_word             = '0;
        cur_word[SFTRST_BIT] = sftrst_q;
        cur_word[GATE_BIT]   = gate_q;
        merged               = wr_en ? alias_merge(op, cur_word, wdata) : cur_word;
        sftrst_d             = merged[SFTRST_BIT];
        // soft reset pins the gate closed
        gate_d               = merged[GATE_BIT] | sftrst_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sftrst_q <= 1'b1;
            gate_q   <= 1'b1;
        end else begin
            sftrst_q <= sftrst_d;
            gate_q   <= gate_d;
        end
    end

    assign run_en = !sftrst_q && !gate_q;

endmodule

// File: rtl/dual_tmr_tick.sv
module dual_tmr_tick
    import dual_tmr_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          active,
    input  logic          restart,
    input  logic [SW-1:0] sel,
    input  logic [PW-1:0] pre,
    input  logic          slow_tick,
    output logic          step
);

    localparam int DIV_W = (1 << PW) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;
    logic             src;

    always_comb begin
        if (sel == SW'(SEL_SLOW)) begin
            src = slow_tick;
        end else if (sel == SW'(SEL_ALWAYS)) begin
            src = 1'b1;
        end else begin
            src = 1'b0;
        end
        mask = ({{(DIV_W-1){1'b0}}, 1'b1} << pre) - {{(DIV_W-1){1'b0}}, 1'b1};
        step = active && src && ((phase_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || !active || restart) begin
            phase_q <= '0;
        end else if (src) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/dual_tmr_channel.sv
module dual_tmr_channel
    import dual_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              run_en,
    input  logic              ctrl_wr,
    input  reg_op_e           ctrl_op,
    input  logic              cnt_wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              slow_tick,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  fixed_q,
    output ch_state_e         state_q,
    output logic              irq
);

    ch_state_e         state_d;
    logic [CTRL_W-1:0] ctrl_d;
    logic [CNT_W-1:0]  count_d;
    logic [CNT_W-1:0]  fixed_d;
    logic              parked;
    logic              step;
    logic              hw_set;
    logic              cnt_load;
    logic              tick_active;
    logic [BUS_W-1:0]  ctrl_merged;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else if (soft_clr) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign parked = (count_q == '0) && !ctrl_q[RELOAD_BIT];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (run_en) state_d = parked ? CH_HELD : CH_RUN;
            end
            CH_RUN: begin
                if (!run_en)     state_d = CH_OFF;
                else if (parked) state_d = CH_HELD;
            end
            CH_HELD: begin
                if (!run_en)      state_d = CH_OFF;
                else if (!parked) state_d = CH_RUN;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        tick_active = (state_q == CH_RUN) && run_en;
        irq         = ctrl_q[FLAG_BIT] && ctrl_q[IEN_BIT];
    end

    dual_tmr_tick u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_clr),
        .active    (tick_active),
        .restart   (cnt_wr),
        .sel       (ctrl_q[SEL_LSB +: SEL_W]),
        .pre       (ctrl_q[PRE_LSB +: PRE_W]),
        .slow_tick (slow_tick),
        .step      (step)
    );

    // ---------------- datapath ----------------
    always_comb begin
        cnt_load    = cnt_wr && ctrl_q[UPDATE_BIT];
        hw_set      = step && !cnt_load && (count_q == CNT_W'(1));
        ctrl_merged = ctrl_wr ? alias_merge(ctrl_op, BUS_W'(ctrl_q), wdata)
                              : BUS_W'(ctrl_q);
        ctrl_d      = ctrl_merged[CTRL_W-1:0] & CTRL_MASK;
        // hardware set takes priority over a software clear
        if (hw_set) ctrl_d[FLAG_BIT] = 1'b1;

        fixed_d = cnt_wr ? wdata[CNT_W-1:0] : fixed_q;

        if (cnt_load) begin
            count_d = wdata[CNT_W-1:0];
        end else if (step) begin
            if (count_q != '0)             count_d = count_q - 1'b1;
            else if (ctrl_q[RELOAD_BIT])   count_d = fixed_q;
            else                           count_d = count_q;
        end else begin
            count_d = count_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            count_q <= '0;
            fixed_q <= '0;
        end else if (soft_clr) begin
            ctrl_q  <= '0;
            count_q <= '0;
            fixed_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            count_q <= count_d;
            fixed_q <= fixed_d;
        end
    end

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import dual_tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic                    slow_tick,
    output logic [NUM_CH-1:0]       irq
);

    localparam int BLK_W = ADDR_W - 3;

    logic                           sftrst_q;
    logic                           gate_q;
    logic                           run_en;
    logic [BLK_W-1:0]               blk;
    reg_op_e                        op;
    logic                           slot_ok;
    logic                           glb_wr;
    logic [NUM_CH-1:0]              ctrl_wr;
    logic [NUM_CH-1:0]              cnt_wr;
    logic [NUM_CH-1:0][CTRL_W-1:0]  ch_ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_count;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_fixed;
    ch_state_e                      ch_state [NUM_CH];

    assign blk     = bus_addr[ADDR_W-1:3];
    assign op      = reg_op_e'(bus_addr[1:0]);
    assign slot_ok = !bus_addr[2];
    assign glb_wr  = bus_wr && slot_ok && (blk == '0) && (op != OP_COUNT);

    dual_tmr_global u_glb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (glb_wr),
        .op       (op),
        .wdata    (bus_wdata),
        .sftrst_q (sftrst_q),
        .gate_q   (gate_q),
        .run_en   (run_en)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit        = slot_ok && (blk == BLK_W'(n + 1));
        assign ctrl_wr[n] = bus_wr && hit && (op != OP_COUNT);
        assign cnt_wr[n]  = bus_wr && hit && (op == OP_COUNT);

        dual_tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_clr  (sftrst_q),
            .run_en    (run_en),
            .ctrl_wr   (ctrl_wr[n]),
            .ctrl_op   (op),
            .cnt_wr    (cnt_wr[n]),
            .wdata     (bus_wdata),
            .slow_tick (slow_tick),
            .ctrl_q    (ch_ctrl[n]),
            .count_q   (ch_count[n]),
            .fixed_q   (ch_fixed[n]),
            .state_q   (ch_state[n]),
            .irq       (irq[n])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (slot_ok && blk == '0 && op != OP_COUNT) begin
            bus_rdata[SFTRST_BIT] = sftrst_q;
            bus_rdata[GATE_BIT]   = gate_q;
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (slot_ok && blk == BLK_W'(n + 1)) begin
                if (op == OP_COUNT) begin
                    bus_rdata = (BUS_W'(ch_count[n]) << (BUS_W / 2)) | BUS_W'(ch_fixed[n]);
                end else begin
                    bus_rdata = BUS_W'(ch_ctrl[n]);
                end
            end
        end
    end

endmodule

// File: rtl/dual_tmr_checker.sv
module dual_tmr_checker
    import dual_tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 5
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_CH-1:0]             irq,
    input logic                          sftrst_q,
    input logic                          gate_q,
    input logic                          run_en,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl,
    input logic [NUM_CH-1:0][CNT_W-1:0]  ch_count
);

    localparam int BLK_W = ADDR_W - 3;

    p_gate_forced_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sftrst_q |-> gate_q);

    p_run_needs_both_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |-> (!sftrst_q && !gate_q));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        logic hit;
        logic cw;
        logic kw;
        logic flag_drop_wr;
        assign hit          = !bus_addr[2] && (bus_addr[ADDR_W-1:3] == BLK_W'(n + 1));
        assign cw           = bus_wr && hit && (bus_addr[1:0] == 2'd3);
        assign kw           = bus_wr && hit && (bus_addr[1:0] != 2'd3);
        assign flag_drop_wr = kw && (bus_addr[1:0] == 2'd0 || bus_addr[1:0] == 2'd2);

        p_irq_off_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
            sftrst_q |=> (!irq[n] && ch_count[n] == '0));

        p_frozen_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en && !cw && !sftrst_q) |=> $stable(ch_count[n]));

        p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cw && !sftrst_q && ch_count[n] != '0) |=>
                (ch_count[n] == $past(ch_count[n]) ||
                 ch_count[n] == $past(ch_count[n]) - CNT_W'(1)));

        p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cw && !sftrst_q && ch_count[n] == '0 && !ch_ctrl[n][RELOAD_BIT]) |=>
                (ch_count[n] == '0));

        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_ctrl[n][FLAG_BIT] && !flag_drop_wr && !sftrst_q) |=> ch_ctrl[n][FLAG_BIT]);

        p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!kw && !sftrst_q && !ch_ctrl[n][FLAG_BIT]) |=>
                (!ch_ctrl[n][FLAG_BIT] || $past(ch_count[n]) == CNT_W'(1)));

        p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[n] |-> ch_ctrl[n][FLAG_BIT]);
    end

endmodule

bind dual_reload_timer dual_tmr_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .sftrst_q (sftrst_q),
    .gate_q   (gate_q),
    .run_en   (run_en),
    .ch_ctrl  (ch_ctrl),
    .ch_count (ch_count)
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 5;

    localparam logic [4:0] A_G    = 5'd0;
    localparam logic [4:0] A_G_S  = 5'd1;
    localparam logic [4:0] A_G_C  = 5'd2;
    localparam logic [4:0] A_C0   = 5'd8;
    localparam logic [4:0] A_C0_S = 5'd9;
    localparam logic [4:0] A_C0_C = 5'd10;
    localparam logic [4:0] A_N0   = 5'd11;
    localparam logic [4:0] A_C1   = 5'd16;
    localparam logic [4:0] A_C1_C = 5'd18;
    localparam logic [4:0] A_N1   = 5'd19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              slow_tick = 1'b0;
    logic [NUM_CH-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb[$];

    always #10 clk = ~clk;

    dual_reload_timer #(.NUM_CH(NUM_CH), .CNT_W(16), .ADDR_W(ADDR_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .slow_tick (slow_tick),
        .irq       (irq)
    );

    // monitor: compares each expected item against the design
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {30'b0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string r);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic expect_irq(input logic [1:0] e, input string r);
        sb_item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {30'b0, e}; it.req = r;
        sb.push_back(it);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; slow_tick = 1'b1;
            @(posedge clk); #1; slow_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        idle(4);
        #1 rst_n = 1'b1;
        // R1 reset state
        expect_rd(A_G,  32'hC000_0000, "R1 global reset value");
        expect_rd(A_C0, 32'h0,         "R1 ch0 control zero");
        expect_rd(A_N1, 32'h0,         "R1 ch1 count zero");
        expect_irq(2'b00,              "R1 irq low");

        // R10 enable via clear alias
        wr(A_G_C, 32'hC000_0000);
        expect_rd(A_G, 32'h0, "R2 global clear alias");

        // ch0: slow tick, divide 1, reload, update, irq enable
        wr(A_C0, 32'h0000_40C8);
        expect_rd(A_C0, 32'h0000_40C8, "R2 ch0 replace write");
        wr(A_N0, 32'h0000_0003);
        expect_rd(A_N0, 32'h0003_0003, "R3 update loads live count");
        idle(3);
        pulse(1);
        expect_rd(A_N0, 32'h0002_0003, "R5 slow tick decrements");
        pulse(2);
        expect_rd(A_N0, 32'h0000_0003, "R7 reached zero");
        expect_rd(A_C0, 32'h0000_C0C8, "R8 flag set at zero");
        expect_irq(2'b01,              "R8 irq0 raised");
        pulse(1);
        expect_rd(A_N0, 32'h0003_0003, "R7 reload from fixed value");
        expect_rd(A_C0, 32'h0000_C0C8, "R8 flag sticky");

        // R2 clear alias touches only the flag
        wr(A_C0_C, 32'h0000_8000);
        expect_rd(A_C0, 32'h0000_40C8, "R2 clear alias only flag");
        expect_irq(2'b00,              "R8 irq0 dropped");

        // R6 prescale 4 via set alias
        wr(A_C0_S, 32'h0000_0020);
        expect_rd(A_C0, 32'h0000_40E8, "R2 set alias");
        wr(A_N0, 32'h0000_0002);
        idle(3);
        pulse(3);
        expect_rd(A_N0, 32'h0002_0002, "R6 no step before 4 ticks");
        pulse(1);
        expect_rd(A_N0, 32'h0001_0002, "R6 step on 4th tick");

        // ch1: every clock, update, irq enable, no reload
        wr(A_C1, 32'h0000_408F);
        wr(A_N1, 32'h0000_0005);
        idle(20);
        expect_rd(A_N1, 32'h0000_0005, "R7 stops at zero without reload");
        expect_rd(A_C1, 32'h0000_C08F, "R5 always-on tick reached zero");
        expect_irq(2'b10,              "R8 irq1 raised");

        // R10 gating freezes ch0
        wr(A_G_S, 32'h4000_0000);
        expect_rd(A_G, 32'h4000_0000, "R10 gate set");
        pulse(8);
        expect_rd(A_N0, 32'h0001_0002, "R10 gated count frozen");

        // R4 write without update
        wr(A_C0_C, 32'h0000_0080);
        wr(A_N0, 32'h0000_0009);
        expect_rd(A_N0, 32'h0001_0009, "R4 live count untouched");
        wr(A_G_C, 32'h4000_0000);
        idle(3);
        pulse(4);
        expect_rd(A_N0, 32'h0000_0009, "R6 resumed step after gate");
        expect_rd(A_C0, 32'h0000_C068, "R8 flag set ch0");
        pulse(4);
        expect_rd(A_N0, 32'h0009_0009, "R7 reload new fixed value");

        // R9 collision: hardware set vs software clear on ch1
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = A_N1;   bus_wdata = 32'h0000_0001;
        @(posedge clk); #1;
        bus_addr = A_C1_C; bus_wdata = 32'h0000_8000;
        @(posedge clk); #1;
        bus_addr = A_C1_C; bus_wdata = 32'h0000_8000;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        expect_rd(A_C1, 32'h0000_C08F, "R9 set wins over clear");
        expect_rd(A_N1, 32'h0000_0001, "R9 count at zero");
        wr(A_C1_C, 32'h0000_8000);
        expect_rd(A_C1, 32'h0000_408F, "R8 plain clear drops flag");

        // R5 unsupported select gives no tick
        wr(A_C1, 32'h0000_4083);
        wr(A_N1, 32'h0000_0004);
        idle(10);
        expect_rd(A_N1, 32'h0004_0004, "R5 other select no tick");

        // R11 soft reset
        wr(A_G_S, 32'h8000_0000);
        idle(2);
        expect_rd(A_G,  32'hC000_0000, "R11 gate forced");
        expect_rd(A_C0, 32'h0,         "R11 ch0 control zeroed");
        expect_rd(A_N0, 32'h0,         "R11 ch0 count zeroed");
        expect_rd(A_N1, 32'h0,         "R11 ch1 count zeroed");
        expect_irq(2'b00,              "R11 irq low");
        wr(A_G_C, 32'h8000_0000);
        expect_rd(A_G, 32'h4000_0000, "R11 gate stays after release");

        idle(3);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard left %0d items", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule